// File: doc/BRIEF.md
# Serial Receive Character Queue

This block is the storage and status stage behind an asynchronous serial receiver. The bit sampler in front of it delivers each frame already assembled, as a one-cycle valid strobe with the data bits, the parity bit as received and the stop bit. The block checks parity when that check is switched on, and it stores every accepted character in a small queue. Each stored character keeps its own parity-error and frame-error status.

Software-style reads go through one port. This port shows the oldest unread character, a receive-complete flag, and the status flags of that character. A read strobe removes the oldest entry. When a frame arrives and the queue has no free slot, the frame is dropped and an overrun indication goes with the oldest entry. Dropping the receiver-enable input empties the queue and discards any frame in the same cycle.

Top module: `rx_char_queue`

## Requirements
- R1: After reset the queue is empty. `rd_ready`, `rd_data`, `rd_perr`, `rd_ferr` and `rd_ovr` are all 0.
- R2: Accepted characters are read out oldest first. `rd_ready` is 1 exactly when at least one entry is unread. `rd_data` bits at and above `DATA_W` read as 0, and all outputs read 0 while the queue is empty.
- R3: With `par_on`=1 a character is flagged when the XOR of its `DATA_W` data bits and the received parity bit differs from `par_odd` (0 = even parity, 1 = odd parity). With `par_on`=0 the flag is stored as 0. The flag shown is the one captured when that character arrived, whatever the current mode.
- R4: `rd_ferr` is 1 for a head character whose received stop bit was 0.
- R5: A `rd_pop` strobe removes the head entry in the following cycle. A strobe while the queue is empty has no effect.
- R6: A frame arriving while all `DEPTH` (default 2) slots are full, with no pop in the same cycle, is not stored. It sets `rd_ovr`, which is shown with the head entry and clears when that entry is popped.
- R7: A frame arriving in the same cycle as a pop of a full queue is stored and does not set `rd_ovr`.
- R8: While `rx_en` is 0, every entry and the overrun indication are cleared at the next clock edge, and arriving frames are ignored.
- R9: Popping repeatedly until `rd_ready` falls empties the queue. It takes exactly as many pops as there were unread entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable; low flushes and blocks input |
| par_on | input | 1 | Parity check active |
| par_odd | input | 1 | Parity type: 0 even, 1 odd |
| frm_valid | input | 1 | One-cycle strobe for a completed frame |
| frm_data | input | 8 | Received data bits, low `DATA_W` used |
| frm_par | input | 1 | Received parity bit |
| frm_stop | input | 1 | Received stop bit |
| rd_pop | input | 1 | Read strobe of the data register, pops the head |
| rd_data | output | 8 | Head character, zero-extended |
| rd_ready | output | 1 | Receive complete: queue not empty |
| rd_perr | output | 1 | Parity error of head character |
| rd_ferr | output | 1 | Frame error of head character |
| rd_ovr | output | 1 | Overrun reported with head character |

## Verification
The hardest cases are the ones on a full queue. A frame can arrive with no pop, which must be dropped and flagged as overrun. A frame can also arrive together with a pop, which must be stored with no flag. The stimulus table fills both slots and then offers a third frame both ways. It also changes the parity mode between frames, to show that each flag belongs to its own character. Flushes through `rx_en` come right after an overrun, so the bench can show that the overrun indication is cleared along with the data.

// File: rtl/rx_char_queue.sv
module rx_char_queue #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en,
  input  logic       par_on,
  input  logic       par_odd,
  input  logic       frm_valid,
  input  logic [7:0] frm_data,
  input  logic       frm_par,
  input  logic       frm_stop,
  input  logic       rd_pop,
  output logic [7:0] rd_data,
  output logic       rd_ready,
  output logic       rd_perr,
  output logic       rd_ferr,
  output logic       rd_ovr
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem_d [DEPTH];
  logic [DEPTH-1:0]  mem_pe, mem_fe;
  logic [PW-1:0]     wp, rp;
  logic [CW-1:0]     cnt;
  logic              ovr;

  wire [DATA_W-1:0] din  = frm_data[DATA_W-1:0];
  wire              take = rx_en && frm_valid;
  wire              full = (cnt == CW'(DEPTH));
  wire              pop  = rx_en && rd_pop && (cnt != '0);
  wire              wr   = take && (!full || pop);
  wire              perr = par_on && ((^din ^ frm_par) != par_odd);

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      ovr <= 1'b0;
    end else if (!rx_en) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      ovr <= 1'b0;
    end else begin
      if (wr)  wp <= bump(wp);
      if (pop) rp <= bump(rp);
      cnt <= cnt + CW'(wr) - CW'(pop);
      if (pop)               ovr <= 1'b0;
      else if (take && full) ovr <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr) begin
      mem_d[wp]  <= din;
      mem_pe[wp] <= perr;
      mem_fe[wp] <= !frm_stop;
    end
  end

  assign rd_ready = (cnt != '0);
  assign rd_data  = rd_ready ? 8'(mem_d[rp]) : 8'h00;
  assign rd_perr  = rd_ready && mem_pe[rp];
  assign rd_ferr  = rd_ready && mem_fe[rp];
  assign rd_ovr   = rd_ready && ovr;
endmodule

// File: rtl/rx_char_queue_chk.sv
module rx_char_queue_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_en,
  input logic       frm_valid,
  input logic       rd_pop,
  input logic [7:0] rd_data,
  input logic       rd_ready,
  input logic       rd_perr,
  input logic       rd_ferr,
  input logic       rd_ovr
);
  p_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && frm_valid |=> rd_ready);

  p_head_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready && !rd_pop && rx_en |=> $stable(rd_data) && $stable(rd_perr) && $stable(rd_ferr));

  p_ferr_has_head_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ferr |-> rd_ready);

  p_pop_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ready && !(rx_en && frm_valid) |=> !rd_ready);

  p_ovr_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_ovr) |-> $past(rx_en && frm_valid && !rd_pop && rd_ready));

  p_ovr_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && rd_ovr && rd_pop |=> !rd_ovr);

  p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rd_ready && !rd_ovr);
endmodule

bind rx_char_queue rx_char_queue_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .frm_valid(frm_valid), .rd_pop(rd_pop),
  .rd_data(rd_data), .rd_ready(rd_ready), .rd_perr(rd_perr), .rd_ferr(rd_ferr),
  .rd_ovr(rd_ovr)
);

// File: tb/rx_char_queue_bench.sv
`timescale 1ns/1ps
module rx_char_queue_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_en = 1'b0, par_on = 1'b0, par_odd = 1'b0, frm_valid = 1'b0;
  logic [7:0] frm_data = 8'h00;
  logic frm_par = 1'b0, frm_stop = 1'b1, rd_pop = 1'b0;
  logic [7:0] rd_data, n_data;
  logic rd_ready, rd_perr, rd_ferr, rd_ovr;
  logic n_ready, n_perr, n_ferr, n_ovr;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  rx_char_queue u_rx_char_queue (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .par_on(par_on), .par_odd(par_odd),
    .frm_valid(frm_valid), .frm_data(frm_data), .frm_par(frm_par), .frm_stop(frm_stop),
    .rd_pop(rd_pop), .rd_data(rd_data), .rd_ready(rd_ready), .rd_perr(rd_perr),
    .rd_ferr(rd_ferr), .rd_ovr(rd_ovr));

  rx_char_queue #(.DATA_W(5)) u_rx_char_queue_narrow (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .par_on(par_on), .par_odd(par_odd),
    .frm_valid(frm_valid), .frm_data(frm_data), .frm_par(frm_par), .frm_stop(frm_stop),
    .rd_pop(rd_pop), .rd_data(n_data), .rd_ready(n_ready), .rd_perr(n_perr),
    .rd_ferr(n_ferr), .rd_ovr(n_ovr));

  typedef struct packed {
    logic en, v; logic [7:0] d; logic p, s, pop, pon, podd;
    logic rdy; logic [7:0] ed; logic eperr, eferr, eovr; logic [3:0] req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{1,1,8'hA5,0,1,0,1,0, 1,8'hA5,0,0,0, 3},  // R3 even parity good
    '{1,1,8'h3C,1,0,0,1,0, 1,8'hA5,0,0,0, 2},  // R2 second slot, head kept
    '{1,1,8'h77,0,1,0,1,0, 1,8'hA5,0,0,1, 6},  // R6 overrun on full
    '{1,0,8'h00,0,1,1,1,0, 1,8'h3C,1,1,0, 4},  // R4 stop 0, R3 parity bad, R6 ovr cleared
    '{1,0,8'h00,0,1,1,1,0, 0,8'h00,0,0,0, 5},  // R5 pop to empty
    '{1,0,8'h00,0,1,1,1,0, 0,8'h00,0,0,0, 5},  // R5 pop on empty ignored
    '{1,1,8'h01,0,1,0,0,0, 1,8'h01,0,0,0, 3},  // R3 check off: no flag
    '{1,1,8'h0F,0,1,0,1,1, 1,8'h01,0,0,0, 3},  // R3 head flag kept from its frame
    '{1,0,8'h00,0,1,1,1,1, 1,8'h0F,1,0,0, 3},  // R3 odd parity bad
    '{1,1,8'h80,0,1,0,1,1, 1,8'h0F,1,0,0, 2},  // R2 fill
    '{1,1,8'h55,1,1,1,1,1, 1,8'h80,0,0,0, 7},  // R7 pop+write when full
    '{1,0,8'h00,0,1,1,1,1, 1,8'h55,0,0,0, 5},  // R5 ordering after R7
    '{0,1,8'h99,0,1,0,1,1, 0,8'h00,0,0,0, 8},  // R8 flush, frame ignored
    '{1,0,8'h00,0,1,0,1,1, 0,8'h00,0,0,0, 8},  // R8 nothing kept
    '{1,1,8'h11,0,1,0,0,0, 1,8'h11,0,0,0, 2},  // R2
    '{1,1,8'h22,0,1,0,0,0, 1,8'h11,0,0,0, 2},  // R2
    '{1,1,8'h33,0,1,0,0,0, 1,8'h11,0,0,1, 6},  // R6
    '{0,0,8'h00,0,1,0,0,0, 0,8'h00,0,0,0, 8},  // R8 flush clears overrun
    '{1,0,8'h00,0,1,0,0,0, 0,8'h00,0,0,0, 8}   // R8 overrun stays clear
  };

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic en, v, input logic [7:0] d, input logic p, s, pop);
    @(negedge clk);
    rx_en = en; frm_valid = v; frm_data = d; frm_par = p; frm_stop = s; rd_pop = pop;
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", {rd_ready, rd_data, rd_perr, rd_ferr, rd_ovr}, 12'h0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      par_on = VEC[i].pon; par_odd = VEC[i].podd;
      rx_en = VEC[i].en; frm_valid = VEC[i].v; frm_data = VEC[i].d;
      frm_par = VEC[i].p; frm_stop = VEC[i].s; rd_pop = VEC[i].pop;
      @(posedge clk); #1;
      check($sformatf("R%0d row %0d", VEC[i].req, i),
            {rd_ready, rd_data, rd_perr, rd_ferr, rd_ovr},
            {VEC[i].rdy, VEC[i].ed, VEC[i].eperr, VEC[i].eferr, VEC[i].eovr});
    end

    // R9: read until receive-complete clears
    par_on = 1'b0;
    step(1, 1, 8'hC1, 0, 1, 0);
    step(1, 1, 8'hC2, 0, 1, 0);
    step(1, 0, 8'h00, 0, 1, 0);
    begin
      int reads = 0;
      while (rd_ready && reads < 5) begin
        step(1, 0, 8'h00, 0, 1, 1);
        reads++;
      end
      check("R9 reads", 12'(reads), 12'd2);
      check("R9 empty", {11'h0, rd_ready}, 12'h0);
    end
    step(1, 0, 8'h00, 0, 1, 0);

    // R2/R3 narrow instance: 5 data bits, even parity over those bits only
    par_on = 1'b1; par_odd = 1'b0;
    step(1, 1, 8'hFF, 1, 1, 0);
    check("R2 narrow upper zero", {3'b0, n_ready, n_data}, {3'b0, 1'b1, 8'h1F});
    check("R3 narrow parity width", {11'h0, n_perr}, 12'h0);
    check("R3 wide same frame bad", {11'h0, rd_perr}, 12'h1);

    // R1: reset mid-run empties the queue
    step(1, 1, 8'h42, 0, 1, 0);
    @(negedge clk); frm_valid = 1'b0; rst_n = 1'b0;
    #1;
    check("R1 reset", {rd_ready, rd_data, rd_perr, rd_ferr, rd_ovr}, 12'h0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 after release", {11'h0, rd_ready}, 12'h0);

    report();
  end
endmodule